// File: doc/BRIEF.md
# Floating-Point Word Store Unit

This unit executes the single-precision floating-point store. It takes one 32-bit instruction word at a time and decodes it. If the word is the store, the unit reads an integer base register and a floating-point source register through two read ports. It adds the sign-extended 12-bit displacement to the base to form a byte address. It then issues one 32-bit memory write over a valid/ready handshake. The value written is the raw low word of the floating-point register. It is not interpreted in any way: a NaN payload passes through unchanged, and on a 64-bit register file the upper half is dropped.

An address that is not word aligned never reaches memory. The unit raises a one-cycle misaligned-store exception pulse instead, and that pulse carries the faulting address. Any instruction word that does not match the store pattern is reported with a one-cycle unhandled-instruction pulse. The unit holds only one instruction at a time, and `busy` tells the issuing stage when it may present the next one.

Top module: `fp_word_store`

## Requirements
- R1: An instruction word is a store only when bits [6:0] are 7'b0100111 and bits [14:12] are 3'b010. Any other word issues no memory request, raises `illegal` for exactly one cycle (two cycles after acceptance), and raises no `done` or exception.
- R2: The displacement is {instr[31:25], instr[11:7]} sign-extended (range -2048..+2047). The effective address is the base register value plus this displacement, modulo 2^XLEN.
- R3: While an instruction is held, `ireg_idx` shows instr[19:15] (integer base register) and `freg_idx` shows instr[24:20] (floating-point data register).
- R4: `mem_wdata` equals bits [31:0] of the floating-point register, copied bit for bit. NaN patterns are unchanged, and bits above 31 of a 64-bit register have no effect.
- R5: When the effective address has bits [1:0] not equal to 2'b00, no memory request is issued. `exc_misaligned` pulses for exactly one cycle, two cycles after acceptance, with `exc_addr` equal to the effective address.
- R6: An aligned store drives `mem_valid` with the effective address, the data and `mem_strb` = 4'b1111. Address and data are held stable until a cycle in which `mem_ready` is high.
- R7: `done` is high for exactly one cycle: the cycle after the clock edge at which `mem_valid` and `mem_ready` are both high.
- R8: An instruction is accepted only when `busy` is low and `instr_valid` is high. `busy` stays high from the acceptance until the write handshake or the exception/unhandled decision, and `instr_valid` has no effect while `busy` is high. A new instruction may be accepted in the same cycle in which `done` is high.
- R9: After reset, `busy`, `mem_valid`, `done`, `exc_misaligned` and `illegal` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word offered |
| instr_word | input | 32 | Instruction word |
| busy | output | 1 | Unit holds an instruction; offers are ignored |
| ireg_idx | output | 5 | Integer register file read index (base) |
| ireg_data | input | XLEN | Integer register read data |
| freg_idx | output | 5 | Floating-point register file read index (data) |
| freg_data | input | FLEN | Floating-point register read data |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | XLEN | Write byte address |
| mem_wdata | output | 32 | Write data |
| mem_strb | output | 4 | Byte strobes, all set |
| done | output | 1 | One-cycle pulse: store completed |
| exc_misaligned | output | 1 | One-cycle pulse: misaligned store exception |
| exc_addr | output | XLEN | Faulting address, valid with exc_misaligned |
| illegal | output | 1 | One-cycle pulse: word is not handled by this unit |

## Verification
Two things can fall in the same cycle: the completion pulse of one store and the acceptance of the next instruction. Both happen in the idle cycle right after the write handshake. The bench keeps `instr_valid` high across a whole store and changes the offered word while the unit is busy. It then checks that only the first word issues a request before `done`. It also checks that the second word is taken exactly at the `done` cycle: busy is seen one cycle later, and the second request appears two cycles after `done` with its own address.

// File: rtl/fpst_pkg.sv
package fpst_pkg;

    localparam logic [6:0] OPC_FP_STORE = 7'b0100111;
    localparam logic [2:0] F3_WORD      = 3'b010;
    localparam int         WORD_W       = 32;
    localparam int         STRB_W       = WORD_W / 8;
    localparam int         DISP_W       = 12;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_WRITE  = 2'd2
    } fpst_state_e;

endpackage

// File: rtl/fpst_decode.sv
module fpst_decode
    import fpst_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] base,
    output logic            is_store,
    output logic [4:0]      base_idx,
    output logic [4:0]      src_idx,
    output logic [XLEN-1:0] eff_addr,
    output logic            misaligned
);

    localparam int EXT_W = XLEN - DISP_W;

    logic [DISP_W-1:0] disp;
    logic [XLEN-1:0]   disp_ext;

    always_comb begin
        is_store   = (instr[6:0] == OPC_FP_STORE) && (instr[14:12] == F3_WORD);
        base_idx   = instr[19:15];
        src_idx    = instr[24:20];
        disp       = {instr[31:25], instr[11:7]};
        disp_ext   = {{EXT_W{disp[DISP_W-1]}}, disp};
        eff_addr   = base + disp_ext;
        misaligned = (eff_addr[1:0] != 2'b00);
    end

endmodule

// File: rtl/fpst_datasel.sv
module fpst_datasel
    import fpst_pkg::*;
#(
    parameter int FLEN = 64
) (
    input  logic [FLEN-1:0]   freg,
    output logic [WORD_W-1:0] word
);

    generate
        if (FLEN == WORD_W) begin : g_narrow
            assign word = freg;
        end else begin : g_wide
            logic unused_box;
            assign word       = freg[WORD_W-1:0];
            assign unused_box = ^freg[FLEN-1:WORD_W];
        end
    endgenerate

endmodule

// File: rtl/fp_word_store.sv
module fp_word_store
    import fpst_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int FLEN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    output logic              busy,
    output logic [4:0]        ireg_idx,
    input  logic [XLEN-1:0]   ireg_data,
    output logic [4:0]        freg_idx,
    input  logic [FLEN-1:0]   freg_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [XLEN-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [STRB_W-1:0] mem_strb,
    output logic              done,
    output logic              exc_misaligned,
    output logic [XLEN-1:0]   exc_addr,
    output logic              illegal
);

    typedef struct packed {
        fpst_state_e       st;
        logic [31:0]       instr;
        logic [XLEN-1:0]   addr;
        logic [WORD_W-1:0] wdata;
        logic              done;
        logic              exc;
        logic              ill;
    } regs_t;

    regs_t r_q, r_d;

    logic              dec_store;
    logic [XLEN-1:0]   dec_addr;
    logic              dec_misal;
    logic [WORD_W-1:0] src_word;

    fpst_decode #(.XLEN(XLEN)) u_decode (
        .instr      (r_q.instr),
        .base       (ireg_data),
        .is_store   (dec_store),
        .base_idx   (ireg_idx),
        .src_idx    (freg_idx),
        .eff_addr   (dec_addr),
        .misaligned (dec_misal)
    );

    fpst_datasel #(.FLEN(FLEN)) u_datasel (
        .freg (freg_data),
        .word (src_word)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.exc  = 1'b0;
        r_d.ill  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (instr_valid) begin
                    r_d.instr = instr_word;
                    r_d.st    = ST_DECODE;
                end
            end
            ST_DECODE: begin
                if (!dec_store) begin
                    r_d.ill = 1'b1;
                    r_d.st  = ST_IDLE;
                end else if (dec_misal) begin
                    r_d.exc  = 1'b1;
                    r_d.addr = dec_addr;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.addr  = dec_addr;
                    r_d.wdata = src_word;
                    r_d.st    = ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (mem_ready) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy           = (r_q.st != ST_IDLE);
    assign mem_valid      = (r_q.st == ST_WRITE);
    assign mem_addr       = r_q.addr;
    assign mem_wdata      = r_q.wdata;
    assign mem_strb       = {STRB_W{1'b1}};
    assign done           = r_q.done;
    assign exc_misaligned = r_q.exc;
    assign exc_addr       = r_q.addr;
    assign illegal        = r_q.ill;

    p_ill_no_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !mem_valid && !done && !exc_misaligned);

    p_req_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_addr[1:0] == 2'b00);

    p_exc_misaligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exc_misaligned |-> exc_addr[1:0] != 2'b00);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_wdata));

    p_done_after_hs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready |=> done && !mem_valid);

    p_pulse_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, exc_misaligned, illegal}));

    p_req_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> busy);

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && instr_valid |=> busy);

endmodule

// File: tb/fp_word_store_bench.sv
module fp_word_store_bench;

    localparam int XW = 32;
    localparam int FW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          instr_valid = 1'b0;
    logic [31:0]   instr_word = '0;
    logic          busy;
    logic [4:0]    ireg_idx, freg_idx;
    logic [XW-1:0] ireg_data;
    logic [FW-1:0] freg_data;
    logic          mem_valid;
    logic          mem_ready = 1'b0;
    logic [XW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [3:0]    mem_strb;
    logic          done, exc_misaligned, illegal;
    logic [XW-1:0] exc_addr;

    logic [XW-1:0] ireg [32];
    logic [FW-1:0] freg [32];

    assign ireg_data = ireg[ireg_idx];
    assign freg_data = freg[freg_idx];

    always #4 clk = ~clk;

    fp_word_store #(.XLEN(XW), .FLEN(FW)) u_fp_word_store (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
        .busy(busy), .ireg_idx(ireg_idx), .ireg_data(ireg_data),
        .freg_idx(freg_idx), .freg_data(freg_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_strb(mem_strb), .done(done),
        .exc_misaligned(exc_misaligned), .exc_addr(exc_addr), .illegal(illegal)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 0;

    // results of one execution
    int            n_req, n_done, n_exc, n_ill, hs, dn, vcnt;
    bit            stable_ok, busy0;
    logic [4:0]    i_idx0, f_idx0;
    logic [XW-1:0] req_addr, exc_a;
    logic [31:0]   req_data;
    logic [3:0]    req_strb;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic [6:0] opc, input logic [2:0] f3,
                                        input logic [4:0] rs2, input logic [4:0] rs1,
                                        input logic [11:0] disp);
        return {disp[11:5], rs2, rs1, f3, disp[4:0], opc};
    endfunction

    function automatic logic [31:0] st_word(input logic [4:0] rs2, input logic [4:0] rs1,
                                            input logic [11:0] disp);
        return enc(7'b0100111, 3'b010, rs2, rs1, disp);
    endfunction

    task automatic exec(input logic [31:0] w, input int lat);
        n_req = 0; n_done = 0; n_exc = 0; n_ill = 0;
        hs = -1; dn = -1; vcnt = 0; stable_ok = 1;
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = w;
        @(negedge clk);
        instr_valid = 1'b0;
        busy0  = busy;
        i_idx0 = ireg_idx;
        f_idx0 = freg_idx;
        for (int i = 0; i < 12; i++) begin
            if (i > 0) @(negedge clk);
            if (mem_valid) begin
                if (vcnt == 0) begin
                    req_addr = mem_addr; req_data = mem_wdata; req_strb = mem_strb;
                    n_req++;
                end else if (mem_addr != req_addr || mem_wdata != req_data) begin
                    stable_ok = 0;
                end
                mem_ready = (vcnt >= lat);
                if (mem_ready) hs = i;
                vcnt++;
            end else begin
                mem_ready = 1'b0;
            end
            if (done) begin n_done++; dn = i; end
            if (exc_misaligned) begin n_exc++; exc_a = exc_addr; end
            if (illegal) n_ill++;
        end
        mem_ready = 1'b0;
    endtask

    task automatic expect_store(input string tag, input logic [XW-1:0] a, input logic [31:0] d);
        chk(n_req == 1, {tag, " R6 one request"}, n_req, 1);
        chk(req_addr == a, {tag, " R2 address"}, req_addr, a);
        chk(req_data == d, {tag, " R4 data"}, req_data, d);
        chk(n_done == 1 && dn == hs + 1, {tag, " R7 done cycle"}, dn, hs + 1);
        chk(n_exc == 0 && n_ill == 0, {tag, " R5 no exception"}, n_exc + n_ill, 0);
    endtask

    task automatic t_reset();
        chk(!busy && !mem_valid && !done && !exc_misaligned && !illegal, "R9 reset state",
            {busy, mem_valid, done, exc_misaligned, illegal}, 0);
    endtask

    task automatic t_basic();
        ireg[10] = 32'h0000_1000;
        freg[3]  = 64'hFFFF_FFFF_3FC0_0000;
        exec(st_word(5'd3, 5'd10, 12'd36), 0);
        chk(busy0 == 1'b1, "R8 busy after accept", busy0, 1);
        chk(i_idx0 == 5'd10, "R3 base index", i_idx0, 10);
        chk(f_idx0 == 5'd3, "R3 data index", f_idx0, 3);
        chk(req_strb == 4'b1111, "R6 strobe", req_strb, 4'hF);
        expect_store("basic", 32'h0000_1024, 32'h3FC0_0000);
    endtask

    task automatic t_disp_limits();
        ireg[5] = 32'h0000_2000;
        freg[7] = 64'h0123_4567_89AB_CDEF;
        exec(st_word(5'd7, 5'd5, 12'h800), 0);
        expect_store("R2 min -2048", 32'h0000_1800, 32'h89AB_CDEF);
        ireg[6] = 32'h0000_1001;
        exec(st_word(5'd7, 5'd6, 12'h7FF), 0);
        expect_store("R2 max +2047", 32'h0000_1800, 32'h89AB_CDEF);
        ireg[8] = 32'hFFFF_FFFC;
        exec(st_word(5'd7, 5'd8, 12'd8), 0);
        expect_store("R2 wrap", 32'h0000_0004, 32'h89AB_CDEF);
    endtask

    task automatic t_nan_raw();
        ireg[1]  = 32'h0000_0100;
        freg[31] = 64'h1234_5678_7F80_0001;
        exec(st_word(5'd31, 5'd1, 12'd0), 0);
        expect_store("R4 signalling NaN raw", 32'h0000_0100, 32'h7F80_0001);
        freg[31] = 64'h0000_0000_FFC1_2345;
        exec(st_word(5'd31, 5'd1, 12'hFFC), 0);
        expect_store("R4 unboxed upper ignored", 32'h0000_00FC, 32'hFFC1_2345);
    endtask

    task automatic t_misaligned();
        ireg[12] = 32'h0000_4000;
        freg[2]  = 64'h0;
        for (int k = 1; k < 4; k++) begin
            exec(st_word(5'd2, 5'd12, 12'(k)), 0);
            chk(n_req == 0, "R5 no request on misaligned", n_req, 0);
            chk(n_exc == 1 && n_done == 0, "R5 one exception pulse", n_exc, 1);
            chk(exc_a == 32'h0000_4000 + k, "R5 faulting address", exc_a, 32'h4000 + k);
        end
    endtask

    task automatic t_illegal();
        exec(enc(7'b0000111, 3'b010, 5'd2, 5'd12, 12'd0), 0);
        chk(n_ill == 1 && n_req == 0 && n_done == 0 && n_exc == 0, "R1 load opcode unhandled",
            n_ill, 1);
        exec(enc(7'b0100111, 3'b011, 5'd2, 5'd12, 12'd0), 0);
        chk(n_ill == 1 && n_req == 0 && n_done == 0 && n_exc == 0, "R1 funct3 011 unhandled",
            n_ill, 1);
    endtask

    task automatic t_slow_mem();
        ireg[20] = 32'h0000_8000;
        freg[21] = 64'hAAAA_AAAA_DEAD_BEEF;
        exec(st_word(5'd21, 5'd20, 12'd16), 3);
        chk(stable_ok, "R6 held stable while not ready", stable_ok, 1);
        chk(hs == 4, "R6 handshake after wait", hs, 4);
        expect_store("R7 slow memory", 32'h0000_8010, 32'hDEAD_BEEF);
    endtask

    task automatic t_back_to_back();
        int nreq = 0, da = -1, rb = -1;
        logic [XW-1:0] a0 = '0, a1 = '0;
        bit b1 = 0;
        ireg[3] = 32'h0000_0400;
        ireg[4] = 32'h0000_0800;
        freg[9] = 64'h0;
        @(negedge clk);
        mem_ready   = 1'b1;
        instr_valid = 1'b1;
        instr_word  = st_word(5'd9, 5'd3, 12'd4);
        @(negedge clk);
        instr_word  = st_word(5'd9, 5'd4, 12'd8);
        for (int i = 0; i < 12; i++) begin
            if (i > 0) @(negedge clk);
            if (mem_valid) begin
                if (nreq == 0) a0 = mem_addr; else begin a1 = mem_addr; rb = i; end
                nreq++;
            end
            if (done && da < 0) da = i;
            if (da >= 0 && i == da + 1) begin b1 = busy; instr_valid = 1'b0; end
        end
        mem_ready = 1'b0;
        chk(nreq == 2, "R8 two requests", nreq, 2);
        chk(a0 == 32'h0000_0404, "R8 offer while busy ignored", a0, 32'h404);
        chk(b1 == 1'b1, "R8 accepted in done cycle", b1, 1);
        chk(rb == da + 2 && a1 == 32'h0000_0808, "R8 second request timing", rb, da + 2);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 32; k++) begin
            ireg[k] = '0;
            freg[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_disp_limits();
        t_nan_raw();
        t_misaligned();
        t_illegal();
        t_slow_mem();
        t_back_to_back();
        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule